// File: doc/BRIEF.md
# Fetch-side address translation buffer with pairwise-order replacement

This block translates instruction fetch addresses through four fully associative translation slots. A lookup request carries a virtual address, an address-space tag, a flag that says whether tags are compared, and the privilege level of the fetch. The block answers with a result code, the slot that matched, and the physical address. Each slot holds a page of 1 KiB, 4 KiB, 64 KiB or 1 MiB. A slot matches when it is valid, its page covers the address, and its tag agrees with the request's tag. The tag check is skipped when the slot is shared or when tag comparison is switched off.

When no slot matches, the block sends one request to a second-level translation table. That table answers on the next cycle. If it answers with an entry, the entry is copied into the slot that the replacement state chooses. The lookup then runs again, so the refilled slot is reported as the hit. Replacement state is a 6-bit field in which each bit records the age order of one pair of slots. A hit rewrites this field with a fixed clear mask and a fixed set mask for the slot that hit. The slot to replace is picked by matching the field against four patterns in a fixed order.

The response stays on the outputs until the consumer accepts it. No new request is taken while a lookup is in progress.

Top module: `fetch_tlb`

## Requirements
- R1: After reset, every slot is invalid, `lruField` is 0, `rspValid` and `utlbReqValid` are low, and `reqReady` is high.
- R2: A lookup that matches exactly one valid slot responds with `rspCode`=0 (ok) and the index of that slot. The physical address takes its page-number bits from the slot and its in-page bits from the request. Size codes 0/1/2/3 give pages of 1 KiB/4 KiB/64 KiB/1 MiB, so 0/2/6/10 of the 22 page-number bits come from the request instead of the slot.
- R3: A hit on slot k rewrites `lruField` as follows, where bit 5 is the most significant bit:
  - k=0 clears bits 5, 4 and 3.
  - k=1 clears bits 2 and 1 and sets bit 5.
  - k=2 clears bit 0 and sets bits 4 and 2.
  - k=3 sets bits 3, 1 and 0.
- R4: The slot to replace is chosen by testing these patterns in order:
  - slot 0 if bits 5, 4 and 3 are all 1;
  - else slot 1 if bit 5 is 0 and bits 2 and 1 are 1;
  - else slot 2 if bits 4 and 2 are 0 and bit 0 is 1;
  - else slot 3 if bits 3, 1 and 0 are all 0.
- R5: When no slot matches, exactly one single-cycle `utlbReqValid` pulse is issued, carrying the request address. If the second-level table then returns an entry, that entry is written into the slot chosen under R4. The response reports that slot as the hit, with `lruField` updated under R3.
- R6: When no slot matches and the second-level table returns no entry, the response is `rspCode`=1 (miss), and `lruField` keeps its value.
- R7: When more than one valid slot matches, the response is `rspCode`=2 (multiple hit). No second-level request is made, and `lruField` keeps its value.
- R8: A user-mode fetch (`reqUser`=1) that hits a slot whose protection bit 1 (`utlbRspUserExec` at refill) is 0 gets `rspCode`=3 (violation). The replacement update still applies. The same fetch in privileged mode gets ok.
- R9: A slot whose tag differs from `reqAsid` matches only if the slot is shared or `reqUseAsid` is 0.
- R10: A response stays valid with unchanged code, index and physical address until `rspReady` is sampled high. `reqReady` stays low from the cycle after a request is taken until the response has been accepted.
- R11: From reset on, `lruField` always matches one of the four patterns of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqAddr | input | 32 | Virtual fetch address |
| reqAsid | input | 8 | Address-space tag of the fetch |
| reqUser | input | 1 | Fetch is in user mode |
| reqUseAsid | input | 1 | Compare slot tags with reqAsid |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer accepts the response |
| rspCode | output | 2 | 0 ok, 1 miss, 2 multiple hit, 3 violation |
| rspIndex | output | 2 | Slot that hit (ok or violation) |
| rspPhys | output | 32 | Translated address (valid when ok) |
| utlbReqValid | output | 1 | Request to the second-level table |
| utlbReqAddr | output | 32 | Address looked up in the second-level table |
| utlbRspValid | input | 1 | Second-level answer present |
| utlbRspHit | input | 1 | Second-level table holds a matching entry |
| utlbRspVpn | input | 22 | Virtual page number of the returned entry |
| utlbRspPpn | input | 22 | Physical page number of the returned entry |
| utlbRspSize | input | 2 | Page size code of the returned entry |
| utlbRspAsid | input | 8 | Tag of the returned entry |
| utlbRspShared | input | 1 | Returned entry ignores tags |
| utlbRspUserExec | input | 1 | Protection bit 1: user-mode fetch allowed |
| lruField | output | 6 | Pairwise-order replacement field |

## Verification
Two functions meet in a single lookup:

- **Refill followed by re-lookup.** A missed fetch triggers a refill, and the re-lookup after it also applies the replacement update and the privilege check. The bench provokes this by fetching a new page in user mode from an entry without user permission. It then checks that the victim slot, the violation code and the updated order field all agree with a model that works from the masks and patterns alone.
- **Overlapping pages.** A 4 KiB page is loaded first, then a 1 MiB page that covers it. Fetching inside the small page must give a multiple-hit result with no second-level request and an unchanged order field.

A long sweep over six pages, with mixed privilege levels, drives the order field through many states and compares every victim choice.

// File: rtl/fetch_tlb_pkg.sv
package fetch_tlb_pkg;
  parameter int ADDR_W     = 32;
  parameter int PAGE_SHIFT = 10;
  parameter int ASID_W     = 8;
  localparam int NUM_SLOTS = 4;
  localparam int IDX_W     = $clog2(NUM_SLOTS);
  localparam int VPN_W     = ADDR_W - PAGE_SHIFT;
  localparam int LRU_W     = NUM_SLOTS * (NUM_SLOTS - 1) / 2;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_MISS  = 2'd1,
    RES_MULTI = 2'd2,
    RES_VIOL  = 2'd3
  } result_e;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
    logic [1:0]       sizeCode;
    logic [ASID_W-1:0] asid;
    logic             shared;
    logic             userExec;
  } tlbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    captureReq;
    logic    writeVictim;
    logic    updateLru;
    logic    loadRsp;
    logic    useHitCode;
    result_e forcedCode;
  } ctrlStrobe_t;

  // page-number bits that come from the slot (1 = slot, 0 = request)
  function automatic logic [VPN_W-1:0] pageMask(input logic [1:0] code);
    case (code)
      2'd0:    pageMask = '1;
      2'd1:    pageMask = ~VPN_W'(3);
      2'd2:    pageMask = ~VPN_W'(63);
      default: pageMask = ~VPN_W'(1023);
    endcase
  endfunction
endpackage

// File: rtl/fetch_tlb_lru.sv
module fetch_tlb_lru
  import fetch_tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             update,
  input  logic [IDX_W-1:0] hitIdx,
  output logic [LRU_W-1:0] lruField,
  output logic [IDX_W-1:0] victimIdx,
  output logic             victimOk
);
  localparam logic [LRU_W-1:0] CLEAR_KEEP [NUM_SLOTS] =
    '{6'b000111, 6'b111001, 6'b111110, 6'b111111};
  localparam logic [LRU_W-1:0] SET_BITS [NUM_SLOTS] =
    '{6'b000000, 6'b100000, 6'b010100, 6'b001011};

  logic [LRU_W-1:0] lruNext;

  always_comb lruNext = (lruField & CLEAR_KEEP[hitIdx]) | SET_BITS[hitIdx];

  always_ff @(posedge clk) begin
    if (!rstN)       lruField <= '0;
    else if (update) lruField <= lruNext;
  end

  // ordered pattern match for the slot to replace
  always_comb begin
    victimOk  = 1'b1;
    victimIdx = IDX_W'(3);
    if (lruField[5:3] == 3'b111)                               victimIdx = IDX_W'(0);
    else if (!lruField[5] && lruField[2] && lruField[1])       victimIdx = IDX_W'(1);
    else if (!lruField[4] && !lruField[2] && lruField[0])      victimIdx = IDX_W'(2);
    else if (!lruField[3] && !lruField[1] && !lruField[0])     victimIdx = IDX_W'(3);
    else                                                       victimOk  = 1'b0;
  end

  assert_victim_defined_R11: assert property (@(posedge clk) disable iff (!rstN)
    victimOk);
endmodule

// File: rtl/fetch_tlb_dp.sv
module fetch_tlb_dp
  import fetch_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              reqUser,
  input  logic              reqUseAsid,
  input  tlbEntry_t         refillEntry,
  output logic              hitNone,
  output logic              hitMulti,
  output logic [ADDR_W-1:0] lookupAddr,
  output logic [1:0]        rspCode,
  output logic [IDX_W-1:0]  rspIndex,
  output logic [ADDR_W-1:0] rspPhys,
  output logic [LRU_W-1:0]  lruField
);
  logic [ADDR_W-1:0] qAddr;
  logic [ASID_W-1:0] qAsid;
  logic              qUser, qUseAsid;
  tlbEntry_t         slot [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hitVec;
  logic [IDX_W-1:0]  hitIdx, victimIdx;
  logic              victimOk;
  logic [VPN_W-1:0]  hitMask, physVpn;
  result_e           hitCode;
  logic [ADDR_W-1:0] hitPhys;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qAddr <= '0; qAsid <= '0; qUser <= 1'b0; qUseAsid <= 1'b0;
    end else if (stb.captureReq) begin
      qAddr <= reqAddr; qAsid <= reqAsid; qUser <= reqUser; qUseAsid <= reqUseAsid;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic [VPN_W-1:0] mask;
    logic             tagOk;
    always_comb begin
      mask     = pageMask(slot[g].sizeCode);
      tagOk    = slot[g].shared || !qUseAsid || (slot[g].asid == qAsid);
      hitVec[g] = slot[g].valid && tagOk &&
                  ((slot[g].vpn & mask) == (qAddr[ADDR_W-1:PAGE_SHIFT] & mask));
    end
    always_ff @(posedge clk) begin
      if (!rstN) slot[g] <= '0;
      else if (stb.writeVictim && victimIdx == IDX_W'(g)) slot[g] <= refillEntry;
    end
  end

  always_comb begin
    hitIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (hitVec[i]) hitIdx = IDX_W'(i);
  end

  assign hitNone  = (hitVec == '0);
  assign hitMulti = !$onehot0(hitVec);
  assign lookupAddr = qAddr;

  always_comb begin
    hitMask = pageMask(slot[hitIdx].sizeCode);
    physVpn = (slot[hitIdx].ppn & hitMask) | (qAddr[ADDR_W-1:PAGE_SHIFT] & ~hitMask);
    hitPhys = {physVpn, qAddr[PAGE_SHIFT-1:0]};
    hitCode = (qUser && !slot[hitIdx].userExec) ? RES_VIOL : RES_OK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspCode <= '0; rspIndex <= '0; rspPhys <= '0;
    end else if (stb.loadRsp) begin
      rspCode  <= stb.useHitCode ? hitCode : stb.forcedCode;
      rspIndex <= hitIdx;
      rspPhys  <= hitPhys;
    end
  end

  fetch_tlb_lru i_lru (
    .clk(clk), .rstN(rstN), .update(stb.updateLru), .hitIdx(hitIdx),
    .lruField(lruField), .victimIdx(victimIdx), .victimOk(victimOk)
  );

  assert_refill_defined_victim_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeVictim |-> victimOk);
  assert_refill_only_on_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeVictim |-> hitNone);
  assert_hit_code_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadRsp && stb.useHitCode) |-> !hitMulti && !hitNone);
endmodule

// File: rtl/fetch_tlb_ctrl.sv
module fetch_tlb_ctrl
  import fetch_tlb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  input  logic        hitNone,
  input  logic        hitMulti,
  input  logic        utlbRspValid,
  input  logic        utlbRspHit,
  output logic        reqReady,
  output logic        rspValid,
  output logic        utlbReqValid,
  output ctrlStrobe_t stb
);
  typedef enum logic [2:0] {S_IDLE, S_LOOKUP, S_UREQ, S_UWAIT, S_RESP} state_e;
  state_e state, stateNext;
  logic   refilled, refilledNext;

  always_comb begin
    stateNext    = state;
    refilledNext = refilled;
    stb          = '0;
    stb.forcedCode = RES_MISS;
    case (state)
      S_IDLE: if (reqValid) begin
        stb.captureReq = 1'b1;
        refilledNext   = 1'b0;
        stateNext      = S_LOOKUP;
      end
      S_LOOKUP: begin
        if (hitMulti) begin
          stb.loadRsp = 1'b1; stb.forcedCode = RES_MULTI; stateNext = S_RESP;
        end else if (!hitNone) begin
          stb.loadRsp = 1'b1; stb.useHitCode = 1'b1; stb.updateLru = 1'b1;
          stateNext   = S_RESP;
        end else if (refilled) begin
          stb.loadRsp = 1'b1; stateNext = S_RESP;
        end else begin
          stateNext = S_UREQ;
        end
      end
      S_UREQ: stateNext = S_UWAIT;
      S_UWAIT: if (utlbRspValid) begin
        if (utlbRspHit) begin
          stb.writeVictim = 1'b1; refilledNext = 1'b1; stateNext = S_LOOKUP;
        end else begin
          stb.loadRsp = 1'b1; stateNext = S_RESP;
        end
      end
      S_RESP: if (rspReady) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; refilled <= 1'b0;
    end else begin
      state <= stateNext; refilled <= refilledNext;
    end
  end

  assign reqReady     = (state == S_IDLE);
  assign rspValid     = (state == S_RESP);
  assign utlbReqValid = (state == S_UREQ);

  assert_utlb_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    utlbReqValid |=> !utlbReqValid);
  assert_rsp_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);
  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);
endmodule

// File: rtl/fetch_tlb.sv
module fetch_tlb
  import fetch_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              reqUser,
  input  logic              reqUseAsid,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [1:0]        rspCode,
  output logic [IDX_W-1:0]  rspIndex,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              utlbReqValid,
  output logic [ADDR_W-1:0] utlbReqAddr,
  input  logic              utlbRspValid,
  input  logic              utlbRspHit,
  input  logic [VPN_W-1:0]  utlbRspVpn,
  input  logic [VPN_W-1:0]  utlbRspPpn,
  input  logic [1:0]        utlbRspSize,
  input  logic [ASID_W-1:0] utlbRspAsid,
  input  logic              utlbRspShared,
  input  logic              utlbRspUserExec,
  output logic [LRU_W-1:0]  lruField
);
  ctrlStrobe_t stb;
  logic        hitNone, hitMulti;
  tlbEntry_t   refillEntry;

  assign refillEntry = '{valid: 1'b1, vpn: utlbRspVpn, ppn: utlbRspPpn,
                         sizeCode: utlbRspSize, asid: utlbRspAsid,
                         shared: utlbRspShared, userExec: utlbRspUserExec};

  fetch_tlb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspReady(rspReady),
    .hitNone(hitNone), .hitMulti(hitMulti), .utlbRspValid(utlbRspValid),
    .utlbRspHit(utlbRspHit), .reqReady(reqReady), .rspValid(rspValid),
    .utlbReqValid(utlbReqValid), .stb(stb)
  );

  fetch_tlb_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqAsid(reqAsid),
    .reqUser(reqUser), .reqUseAsid(reqUseAsid), .refillEntry(refillEntry),
    .hitNone(hitNone), .hitMulti(hitMulti), .lookupAddr(utlbReqAddr),
    .rspCode(rspCode), .rspIndex(rspIndex), .rspPhys(rspPhys), .lruField(lruField)
  );

  assert_rsp_data_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> ($stable(rspCode) && $stable(rspIndex) && $stable(rspPhys)));
  assert_lru_kept_on_miss_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rspValid) && rspCode == 2'd1) |-> $stable(lruField));
  assert_lru_kept_on_multi_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rspValid) && rspCode == 2'd2) |-> $stable(lruField));
endmodule

// File: tb/test_fetch_tlb.sv
`timescale 1ns/1ps
module test_fetch_tlb;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqUser = 1'b0, reqUseAsid = 1'b0, rspReady = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  reqAsid = '0;
  logic reqReady, rspValid, utlbReqValid;
  logic [1:0] rspCode, rspIndex;
  logic [31:0] rspPhys, utlbReqAddr;
  logic utlbRspValid = 1'b0, utlbRspHit = 1'b0, utlbRspShared = 1'b0, utlbRspUserExec = 1'b0;
  logic [21:0] utlbRspVpn = '0, utlbRspPpn = '0;
  logic [1:0]  utlbRspSize = '0;
  logic [7:0]  utlbRspAsid = '0;
  logic [5:0]  lruField;

  int errors = 0, checks = 0, ureqCount = 0;
  bit done = 0;
  // second-level table configuration
  bit uHit = 1, uSh = 1, uPr = 1;
  logic [1:0] uSz = 2'd1;
  logic [7:0] uAsid = 8'd0;
  // model of slots and order field
  bit mV [4];
  logic [21:0] mVpn [4], mPpn [4];
  logic [1:0] mSz [4];
  logic [7:0] mAsid [4];
  bit mSh [4], mPr [4];
  logic [5:0] mLru = '0;

  always #4 clk = ~clk;

  fetch_tlb i_fetch_tlb (.*);

  function automatic logic [21:0] benchPpn(input logic [21:0] v);
    return v ^ 22'h0ABCD;
  endfunction

  always @(posedge clk) begin
    utlbRspValid <= utlbReqValid;
    if (utlbReqValid) begin
      ureqCount++;
      utlbRspHit <= uHit; utlbRspVpn <= utlbReqAddr[31:10];
      utlbRspPpn <= benchPpn(utlbReqAddr[31:10]); utlbRspSize <= uSz;
      utlbRspAsid <= uAsid; utlbRspShared <= uSh; utlbRspUserExec <= uPr;
    end
  end

  function automatic int lowBits(input logic [1:0] s);
    case (s) 2'd0: return 0; 2'd1: return 2; 2'd2: return 6; default: return 10; endcase
  endfunction

  // R3 masks
  function automatic logic [5:0] lruNext(input logic [5:0] f, input int k);
    case (k)
      0: return f & 6'b000111;
      1: return (f & 6'b111001) | 6'b100000;
      2: return (f & 6'b111110) | 6'b010100;
      default: return f | 6'b001011;
    endcase
  endfunction

  // R4 ordered patterns
  function automatic int victimOf(input logic [5:0] f);
    if (f[5:3] == 3'b111) return 0;
    if (!f[5] && f[2] && f[1]) return 1;
    if (!f[4] && !f[2] && f[0]) return 2;
    if (!f[3] && !f[1] && !f[0]) return 3;
    return -1;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [7:0] asid, input bit user,
                        input bit useAsid, input int hold, input string tag);
    int cnt = 0, idx = -1, expCode, startReq;
    logic [21:0] mask;
    logic [31:0] expPhys = '0, c0, p0, i0;
    for (int i = 0; i < 4; i++) begin
      mask = ~((22'd1 << lowBits(mSz[i])) - 22'd1);
      if (mV[i] && (mSh[i] || !useAsid || mAsid[i] == asid) &&
          ((mVpn[i] & mask) == (a[31:10] & mask))) begin
        cnt++; idx = i;
      end
    end
    expCode = 2;
    if (cnt == 0) begin
      if (uHit) begin
        idx = victimOf(mLru);
        if (idx < 0) idx = 3;
        mV[idx] = 1; mVpn[idx] = a[31:10]; mPpn[idx] = benchPpn(a[31:10]);
        mSz[idx] = uSz; mAsid[idx] = uAsid; mSh[idx] = uSh; mPr[idx] = uPr;
      end else begin
        expCode = 1;
      end
    end
    if (cnt <= 1 && idx >= 0) begin
      expCode = (user && !mPr[idx]) ? 3 : 0;
      mask = ~((22'd1 << lowBits(mSz[idx])) - 22'd1);
      expPhys = {(mPpn[idx] & mask) | (a[31:10] & ~mask), a[9:0]};
      mLru = lruNext(mLru, idx);
    end
    @(negedge clk);
    startReq = ureqCount;
    reqValid = 1; reqAddr = a; reqAsid = asid; reqUser = user; reqUseAsid = useAsid;
    @(negedge clk);
    reqValid = 0;
    while (!rspValid) @(negedge clk);
    c0 = 32'(rspCode); i0 = 32'(rspIndex); p0 = rspPhys;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(32'(rspValid), 1, "R10 response held");
      chk(32'(reqReady), 0, "R10 busy while response pending");
      chk(32'(rspCode), c0, "R10 code stable");
      chk(32'(rspIndex), i0, "R10 index stable");
      chk(rspPhys, p0, "R10 phys stable");
    end
    chk(32'(rspCode), 32'(expCode), {tag, " code"});
    if (expCode == 0 || expCode == 3) chk(32'(rspIndex), 32'(idx), {tag, " R4 slot index"});
    if (expCode == 0) chk(rspPhys, expPhys, {tag, " R2 physical address"});
    chk(32'(lruField), 32'(mLru), {tag, " R3 order field"});
    chk(32'(ureqCount - startReq), (cnt == 0) ? 1 : 0, {tag, " R5 second-level requests"});
    checks++;
    if (victimOf(lruField) < 0) begin
      errors++;
      $display("FAIL R11 field %b matches no pattern actual=none expected=pattern", lruField);
    end
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    chk(32'(rspValid), 0, "R10 response dropped after accept");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 4; i++) begin
      mV[i] = 0; mVpn[i] = '0; mPpn[i] = '0; mSz[i] = '0; mAsid[i] = '0; mSh[i] = 0; mPr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(32'(lruField), 0, "R1 order field after reset");
    chk(32'(rspValid), 0, "R1 no response after reset");
    chk(32'(reqReady), 1, "R1 ready after reset");
    chk(32'(utlbReqValid), 0, "R1 no second-level request after reset");

    // R5 refill into slot chosen by R4, then R2 hit on same page
    access(32'h0001_0000, 8'd0, 0, 0, 0, "R5 first refill");
    access(32'h0001_0123, 8'd0, 0, 0, 0, "R2 hit refilled page");
    access(32'h0002_0000, 8'd0, 1, 0, 0, "R5 second refill");
    // R8 violation on user fetch without permission, ok when privileged
    uPr = 0;
    access(32'h0003_0400, 8'd0, 1, 0, 0, "R8 user fetch refill violation");
    access(32'h0003_0404, 8'd0, 0, 0, 0, "R8 privileged fetch ok");
    access(32'h0003_0408, 8'd0, 1, 0, 0, "R8 user fetch hit violation");
    uPr = 1;
    // R6 second-level miss
    uHit = 0;
    access(32'h0050_0000, 8'd0, 0, 0, 0, "R6 second-level miss");
    uHit = 1;
    // R7 overlapping pages, response held (R10)
    uSz = 2'd1;
    access(32'h0040_1000, 8'd0, 0, 0, 0, "R7 small page refill");
    uSz = 2'd3;
    access(32'h0040_8000, 8'd0, 0, 0, 0, "R7 large page refill");
    access(32'h0040_1010, 8'd0, 0, 0, 3, "R7 multiple hit");
    // R9 tags
    uSz = 2'd1; uSh = 0; uAsid = 8'd5;
    access(32'h0060_0000, 8'd5, 0, 1, 0, "R9 tagged refill");
    uHit = 0;
    access(32'h0060_0010, 8'd6, 0, 1, 0, "R9 foreign tag misses");
    access(32'h0060_0020, 8'd6, 0, 0, 2, "R9 tag compare off hits");
    access(32'h0060_0030, 8'd5, 0, 1, 0, "R9 own tag hits");
    uHit = 1; uSh = 1; uAsid = 8'd0;
    // R2 page sizes: inside and just beyond each page
    for (int s = 0; s < 4; s++) begin
      logic [31:0] base = 32'h0800_0000 + (32'(s) << 24);
      logic [31:0] span = 32'd1024 << lowBits(2'(s));
      uSz = 2'(s);
      access(base, 8'd0, 0, 0, 0, "R2 size base refill");
      access(base + span - 32'd4, 8'd0, 0, 0, 0, "R2 size last word");
      access(base + span, 8'd0, 0, 0, 0, "R2 size next page");
    end
    // R3 and R4 sweep over six pages
    uSz = 2'd1;
    for (int n = 0; n < 60; n++) begin
      int pg;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pg = int'(lfsr[2:0]) % 6;
      uPr = pg[0];
      access(32'h1000_0000 + 32'(pg) * 32'h1000 + {22'd0, lfsr[12:5], 2'b00},
             8'd0, lfsr[3], 0, 0, "R3 R4 sweep");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule